// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for Clause 22 management frames on an MDC/MDIO pair. Software sets up a control register once, holding the MDC divider and a preamble switch. It then writes a 32-bit command word whose bits already form the management frame: start, opcode, PHY address, register address, turnaround and data. The block shifts that word out MSB first on MDIO. Before the frame it can send an optional run of 32 ones.

A write to the command register starts exactly one frame. The busy flag in the control register stays set until the frame is over, so software polls it. For a read opcode the master lets go of MDIO for the turnaround and the data phase. It clocks the PHY's 16 data bits in on rising MDC edges and places them in the low half of the command register, where software collects them once busy has cleared.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, MDC is low, the MDIO output enable is 0, and both registers read back as 0.
- R2: The control register at offset 0x0 holds the MDC divider in bits 6:0 and the preamble enable in bit 7, and reads back as written. Bit 8 reads as busy, and a 1 written there has no effect.
- R3: While a frame runs, MDC toggles every D system clocks, where D is the programmed divider. A divider of 0 acts as 1. MDC stays low whenever no frame is running.
- R4: A write to offset 0x4 while idle starts a frame. Busy reads 1 on the first read after that write and stays 1 until the frame ends.
- R5: When bit 7 is 1, the master drives 32 one bits before the frame. When bit 7 is 0, the frame starts at once.
- R6: The frame is the 32-bit command word shifted MSB first, with bit 31 always sent as 0. MDIO changes only on falling MDC edges, and the PHY samples it on rising edges.
- R7: With opcode 01 in bits 29:28 (a write), the master drives all 32 frame bits. These include the turnaround in bits 17:16 and the data in bits 15:0.
- R8: With opcode 10 in bits 29:28 (a read), the master releases MDIO for the last 18 frame bits (turnaround plus data). It samples the 16 data bits on rising MDC edges, MSB first. After the frame, bits 15:0 of offset 0x4 hold those bits and bits 31:16 keep the command.
- R9: A write to offset 0x4 while busy is 1 is ignored. No second frame is sent and the register keeps the running command.
- R10: Once the last frame bit has been sent, the output enable drops to 0, MDC rests low and busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset (0x0 control, 0x4 command/data) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Frames are launched with several combinations of opcode, preamble setting and divider: a write with preamble at a large divider, and reads with and without preamble whose returned data have set bits at both ends. Together they separate the drive pattern of writes from the release pattern of reads, and show whether the preamble count depends on bit 7. A command with bit 31 set shows that the leading frame bit is forced low. A second command written during a running frame shows whether it is ignored. Measuring MDC periods at divider 3 and divider 0 separates the normal divide from the zero-as-one rule.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  // frame geometry
  localparam int FRAME_W     = 32;
  localparam int DATA_W      = 16;
  localparam int RELEASE_IDX = 14;  // first frame bit not driven in a read
  localparam int CAPTURE_IDX = 16;  // first frame bit sampled in a read
  localparam int CTRL_OFS    = 0;
  localparam int CMD_OFS     = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_RSV  = 2'b11
  } mdio_op_e;

  // system clocks per MDC half period
  function automatic int unsigned half_period(input int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

  // bit image actually shifted on the wire
  function automatic logic [FRAME_W-1:0] frame_word(input logic [FRAME_W-1:0] cmd);
    logic [FRAME_W-1:0] w;
    w = cmd;
    w[FRAME_W-1] = 1'b0;
    return w;
  endfunction

  function automatic logic cmd_is_read(input logic [1:0] op);
    return mdio_op_e'(op) == OP_RD;
  endfunction

  // master lets go of the line from the turnaround on in a read
  function automatic logic line_released(input logic rd, input logic pre,
                                         input logic [4:0] idx);
    return rd && !pre && (idx >= 5'(RELEASE_IDX));
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  import mdio_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;
  logic             tick;

  always_comb begin
    last = DIV_W'(half_period(int'(div)) - 1);
  end

  assign tick     = run && (cnt_q == last);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine #(
  parameter int PRE_LEN = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic [mdio_pkg::FRAME_W-1:0] cmd,
  input  logic                        pre_en,
  input  logic                        rise_evt,
  input  logic                        fall_evt,
  input  logic                        mdio_i,
  output logic                        busy,
  output logic                        mdio_o,
  output logic                        mdio_oe,
  output logic                        done,
  output logic                        rx_valid,
  output logic [mdio_pkg::DATA_W-1:0] rx_data
);
  import mdio_pkg::*;

  localparam int IDX_W  = $clog2(FRAME_W);
  localparam int PRE_CW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;

  logic               busy_q;
  logic               in_pre_q;
  logic               is_rd_q;
  logic [PRE_CW-1:0]  pre_cnt_q;
  logic [IDX_W-1:0]   fidx_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [DATA_W-1:0]  rx_sh_q;
  logic               last_bit;
  logic               capture;

  assign last_bit = !in_pre_q && (fidx_q == IDX_W'(FRAME_W - 1));
  assign done     = busy_q && fall_evt && last_bit;
  assign capture  = busy_q && rise_evt && is_rd_q && !in_pre_q &&
                    (fidx_q >= IDX_W'(CAPTURE_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      in_pre_q  <= 1'b0;
      is_rd_q   <= 1'b0;
      pre_cnt_q <= '0;
      fidx_q    <= '0;
      shreg_q   <= '0;
      rx_sh_q   <= '0;
    end else if (launch) begin
      busy_q    <= 1'b1;
      in_pre_q  <= pre_en;
      is_rd_q   <= cmd_is_read(cmd[29:28]);
      pre_cnt_q <= '0;
      fidx_q    <= '0;
      shreg_q   <= frame_word(cmd);
    end else if (busy_q) begin
      if (capture) rx_sh_q <= {rx_sh_q[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (in_pre_q) begin
          if (pre_cnt_q == PRE_CW'(PRE_LEN - 1)) in_pre_q <= 1'b0;
          else pre_cnt_q <= pre_cnt_q + 1'b1;
        end else if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          fidx_q  <= fidx_q + 1'b1;
          shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy     = busy_q;
  assign mdio_o   = busy_q && (in_pre_q || shreg_q[FRAME_W-1]);
  assign mdio_oe  = busy_q && !line_released(is_rd_q, in_pre_q, fidx_q);
  assign rx_valid = done && is_rd_q;
  assign rx_data  = rx_sh_q;

  // R6
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_evt) |=> $stable(mdio_o));
  // R5
  pre_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_pre_q) |-> (fidx_q == '0));
  // R8
  rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !mdio_oe);
endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
module mdio_csr #(
  parameter int DIV_W  = 7,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic                         busy,
  input  logic                         rx_valid,
  input  logic [mdio_pkg::DATA_W-1:0]  rx_data,
  output logic [DIV_W-1:0]             div,
  output logic                         pre_en,
  output logic                         launch,
  output logic [31:0]                  cmd
);
  import mdio_pkg::*;

  localparam int PAD_W = 32 - DIV_W - 2;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);

  logic             ctrl_sel;
  logic             cmd_sel;
  logic [DIV_W-1:0] div_q;
  logic             pre_q;
  logic [31:0]      cmd_q;

  assign ctrl_sel = (bus_addr == CTRL_A);
  assign cmd_sel  = (bus_addr == CMD_A);
  assign launch   = bus_wr && cmd_sel && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (bus_wr && ctrl_sel) begin
        div_q <= bus_wdata[DIV_W-1:0];
        pre_q <= bus_wdata[DIV_W];
      end
      if (launch) cmd_q <= bus_wdata;
      else if (rx_valid) cmd_q[DATA_W-1:0] <= rx_data;
    end
  end

  always_comb begin
    if (ctrl_sel)     bus_rdata = {{PAD_W{1'b0}}, busy, pre_q, div_q};
    else if (cmd_sel) bus_rdata = cmd_q;
    else              bus_rdata = '0;
  end

  assign div    = div_q;
  assign pre_en = pre_q;
  assign cmd    = cmd_q;

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cmd_sel && busy && !rx_valid) |=> $stable(cmd_q));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int DIV_W   = 7,
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  import mdio_pkg::*;

  logic [DIV_W-1:0]  div;
  logic              pre_en;
  logic              launch;
  logic [31:0]       cmd;
  logic              busy;
  logic              done;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic              rise_evt;
  logic              fall_evt;

  mdio_csr #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) csr_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .div(div), .pre_en(pre_en),
    .launch(launch), .cmd(cmd)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .mdc(mdc),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) engine_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(bus_wdata),
    .pre_en(pre_en), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  // R10
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));
  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!mdc && $past(done)));
endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         mdc, mdio_o, mdio_oe;
  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b1;
  wire         mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0;
  int failed = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    int          pre;
    logic [31:0] bits;
    logic [31:0] mask;
    string       req;
  } frame_t;
  frame_t exp_q[$];

  // PHY model and monitor
  logic [15:0] rd_value = '0;
  bit          in_frame = 0;
  bit          rd_mode = 0;
  int          fcnt = 0;
  int          pre_ones = 0;
  int          frames_seen = 0;
  logic [31:0] obs_bits = '0;
  logic [31:0] obs_mask = '0;

  always @(posedge mdc) begin
    if (in_frame) begin
      obs_bits[31-fcnt] = mdio_oe ? mdio_o : 1'b0;
      obs_mask[31-fcnt] = mdio_oe;
      fcnt++;
      if (fcnt == 14) rd_mode = (obs_bits[29:28] == 2'b10);
    end else if (mdio_oe) begin
      if (mdio_o) pre_ones++;
      else begin
        in_frame = 1;
        obs_bits = '0;
        obs_mask = 32'h8000_0000;
        fcnt = 1;
      end
    end
  end

  task automatic finish_frame();
    frame_t e;
    phy_oe = 1'b0;
    frames_seen++;
    if (exp_q.size() == 0) begin
      check(0, "R9 unexpected frame", obs_bits, 32'h0);
    end else begin
      e = exp_q.pop_front();
      check(pre_ones == e.pre, {e.req, " R5 preamble count"}, pre_ones, e.pre);
      check(obs_mask == e.mask, {e.req, " drive mask"}, obs_mask, e.mask);
      check((obs_bits & e.mask) == e.bits, {e.req, " R6 frame bits"},
            obs_bits & e.mask, e.bits);
    end
    in_frame = 0;
    rd_mode = 0;
    pre_ones = 0;
  endtask

  always @(negedge mdc) begin
    if (in_frame) begin
      if (fcnt == 32) finish_frame();
      else if (rd_mode && fcnt == 15) begin
        phy_oe = 1'b1;
        phy_val = 1'b0;
      end else if (rd_mode && fcnt >= 16) begin
        phy_val = rd_value[31-fcnt];
      end
    end
  end

  // bus tasks
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 20000; i++) begin
      bus_read(4'h0, r);
      if (!r[8]) break;
    end
  endtask

  // driver: push expectation, then launch
  task automatic send_cmd(input logic [31:0] c, input bit pre, input string req);
    frame_t e;
    e.pre  = pre ? 32 : 0;
    e.mask = (c[29:28] == 2'b10) ? 32'hFFFC_0000 : 32'hFFFF_FFFF;
    e.bits = {1'b0, c[30:0]} & e.mask;
    e.req  = req;
    exp_q.push_back(e);
    bus_write(4'h4, c);
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [31:0] ca;
    int n0;
    longint t0, t1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1
    bus_read(4'h0, r); check(r == 0, "R1 ctrl after reset", r, 0);
    bus_read(4'h4, r); check(r == 0, "R1 cmd after reset", r, 0);
    check({mdc, mdio_oe} == 2'b00, "R1 mdc/oe after reset", {mdc, mdio_oe}, 0);

    // R2: busy bit written as 1 must read 0
    bus_write(4'h0, 32'h0000_019A);
    bus_read(4'h0, r); check(r == 32'h9A, "R2 ctrl readback", r, 32'h9A);

    // R7 write frame with preamble, R4 busy
    send_cmd(mk(2'b01, 5'd5, 5'd3, 16'hBEEF), 1, "R7 write+pre");
    bus_read(4'h0, r); check(r[8] == 1'b1, "R4 busy after launch", r[8], 1);
    wait_idle();
    check({mdc, mdio_oe} == 2'b00, "R10 idle after frame", {mdc, mdio_oe}, 0);
    check(frames_seen == 1, "R4 one frame", frames_seen, 1);

    // R8 read, no preamble
    bus_write(4'h0, 32'h02);
    rd_value = 16'hA5C3;
    ca = mk(2'b10, 5'd1, 5'd2, 16'h0);
    send_cmd(ca, 0, "R8 read");
    wait_idle();
    bus_read(4'h4, r);
    check(r == {ca[31:16], 16'hA5C3}, "R8 read data", r, {ca[31:16], 16'hA5C3});

    // R8 read with preamble
    bus_write(4'h0, 32'h81);
    rd_value = 16'h8001;
    ca = mk(2'b10, 5'd31, 5'd17, 16'h1234);
    send_cmd(ca, 1, "R8 read+pre");
    wait_idle();
    bus_read(4'h4, r);
    check(r[15:0] == 16'h8001, "R8 read data pre", r[15:0], 16'h8001);

    // R6 bit 31 forced low
    bus_write(4'h0, 32'h02);
    send_cmd(32'h8000_0000 | mk(2'b01, 5'd9, 5'd0, 16'h00FF), 0, "R6 bit31");
    wait_idle();

    // R9 write while busy
    bus_write(4'h0, 32'h04);
    n0 = frames_seen;
    ca = mk(2'b01, 5'd2, 5'd4, 16'h5A5A);
    send_cmd(ca, 0, "R9 first");
    bus_write(4'h4, mk(2'b10, 5'd7, 5'd7, 16'h0));
    wait_idle();
    bus_read(4'h4, r); check(r == ca, "R9 register kept", r, ca);
    repeat (300) @(negedge clk);
    check(frames_seen == n0 + 1, "R9 no extra frame", frames_seen, n0 + 1);
    check(mdc == 1'b0, "R3 mdc idle low", mdc, 0);

    // R3 divider 3 and divider 0
    bus_write(4'h0, 32'h03);
    send_cmd(mk(2'b01, 5'd0, 5'd1, 16'h0F0F), 0, "R3 div3");
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check(t1 - t0 == 120, "R3 period div3", 32'(t1 - t0), 120);
    wait_idle();
    bus_write(4'h0, 32'h00);
    send_cmd(mk(2'b01, 5'd0, 5'd1, 16'hF0F0), 0, "R3 div0");
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check(t1 - t0 == 40, "R3 period div0", 32'(t1 - t0), 40);
    wait_idle();
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    summary();
  end
endmodule